// File: doc/BRIEF.md
# Camera Control Bus Slave Register Interface

This block is a bus slave for a three-wire serial camera control bus. The bus has an active-low frame enable, a serial clock and a shared data line. All three bus inputs are oversampled by a faster system clock. When the enable line falls, the slave starts to decode a frame. The first byte of the frame carries a 7-bit device identifier and a direction bit. If the identifier equals the `DEV_ID` parameter, the frame addresses this slave.

A write frame has two or three phases. Its second phase sets a register pointer. Its third phase writes one byte into a small internal register file at that pointer. A read frame has two phases and carries no pointer. The slave returns the byte at the pointer that the most recent write frame latched, whether that write had two or three phases. One register of the file records transfer health. It holds 0x55 from reset and changes to 0x54 when an addressed frame stops after the eight data bits of a phase but before that phase's ninth bit. Local logic reads and writes the same register file through a synchronous port.

The slave drives the data line only through an output-enable. Every enable change is made while the bus clock is low, and no sooner than `HOLD_CYC` system cycles after the clock falls.

Top module: `cam_ctl_slave`

## Requirements
- R1: After reset the output-enable is 0, the status register (index `STAT_ADDR`, default 15) reads 0x55 and every other register reads 0x00.
- R2: A three-phase write frame (first byte `{DEV_ID, 0}`, then pointer byte, then data byte) stores the data byte at the pointer. The pointer is the low `ADDR_W` bits of the second byte.
- R3: A frame whose 7-bit identifier differs from `DEV_ID` changes no register, and the output-enable stays 0 for the whole frame.
- R4: A two-phase read frame (first byte `{DEV_ID, 1}`) returns, most significant bit first, the byte at the pointer latched by the latest two- or three-phase write frame. The master samples each bit while the bus clock is high.
- R5: The slave releases the data line before the ninth bit of the read-data phase, so the output-enable is 0 while that bit's clock is high.
- R6: In an addressed frame, the slave drives 0 on the ninth bit of every phase the master sends.
- R7: The output-enable changes only while the bus clock is low, and never earlier than `HOLD_CYC` system cycles after the clock falls.
- R8: If an addressed frame stops after the eight data bits of an expected phase but before its ninth bit, the status register becomes 0x54.
- R9: The status register can be read and written over the bus like any other register.
- R10: A frame that stops partway through the data bits of a phase discards the partial byte, writes nothing and leaves the status register unchanged.
- R11: While the enable line is high, activity on the clock and data inputs writes nothing and never turns on the output-enable.
- R12: A local write stores a byte that a bus read then returns. A local read presents the addressed byte one system cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cam_en_ni | input | 1 | Bus frame enable, active low |
| cam_clk_i | input | 1 | Bus serial clock |
| cam_dat_i | input | 1 | Bus data line as received |
| cam_dat_o | output | 1 | Value driven onto the data line |
| cam_dat_oe_o | output | 1 | Output-enable for the data line driver |
| loc_we_i | input | 1 | Local register write strobe |
| loc_addr_i | input | ADDR_W | Local register index |
| loc_wdata_i | input | 8 | Local write byte |
| loc_rdata_o | output | 8 | Local read byte, registered |

## Verification
The bench targets these corner cases, one at a time:
- Frames cut short in two places: partway through a data byte, and exactly after eight data bits. A design that commits on the eighth bit would write the partial byte. One that ignores the missing ninth bit would leave the status at 0x55.
- Read-backs after both lengths of write frame. A slave that resets its pointer at the start of a frame would return the wrong register.
- The ninth bit of a read. A driver that stays on too long would be caught driving against the master's NA bit.
- An early sample of the output-enable just after the clock falls on a ninth bit. This catches a hold timer that is missing or too short.
- Traffic with a foreign identifier and toggling with the enable held high. A decoder that does not gate on the identifier or the enable would write registers or drive the line.

// File: rtl/cam_ctl_pkg.sv
package cam_ctl_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {PH_ID, PH_SUB, PH_DATA, PH_OVER} phase_e;
  localparam byte_t STAT_RESET = 8'h55;
  localparam byte_t STAT_ERR   = 8'h54;
endpackage

// File: rtl/cam_ctl_sync.sv
module cam_ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[s] <= '1;  // idle bus reads high
      else if (s == 0) st[s] <= d_i;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/cam_ctl_regs.sv
module cam_ctl_regs
  import cam_ctl_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_set_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_waddr_i,
  input  byte_t             bus_wdata_i,
  input  logic [ADDR_W-1:0] bus_raddr_i,
  output byte_t             bus_rdata_o,
  input  logic              loc_we_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  byte_t             loc_wdata_i,
  output byte_t             loc_rdata_o
);
  localparam int NREG = 1 << ADDR_W;

  byte_t regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    localparam bit    IS_STAT = (IDX == STAT_ADDR);
    localparam byte_t RST_VAL = IS_STAT ? STAT_RESET : 8'h00;
    // priority: error record > bus write > local write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs[g] <= RST_VAL;
      else if (IS_STAT && err_set_i) regs[g] <= STAT_ERR;
      else if (bus_we_i && bus_waddr_i == IDX) regs[g] <= bus_wdata_i;
      else if (loc_we_i && loc_addr_i == IDX) regs[g] <= loc_wdata_i;
    end
  end

  assign bus_rdata_o = regs[bus_raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loc_rdata_o <= '0;
    else loc_rdata_o <= regs[loc_addr_i];
  end
endmodule

// File: rtl/cam_ctl_frame.sv
module cam_ctl_frame
  import cam_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h21,
  parameter int         ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  byte_t             rd_byte_i,
  output logic              match_o,
  output logic              rd_o,
  output phase_e            phase_o,
  output logic [ADDR_W-1:0] sub_o,
  output logic              we_o,
  output byte_t             wdata_o,
  output logic              err_o,
  output logic              plan_vld_o,
  output logic              plan_oe_o,
  output logic              plan_dat_o
);
  logic       en_q, sclk_q, active;
  logic [3:0] bit_cnt;
  byte_t      shreg;

  wire start   = en_q & ~en_s_i;
  wire stop    = ~en_q & en_s_i;
  wire rise    = ~sclk_q & sclk_i;
  wire fall    = sclk_q & ~sclk_i;
  wire ninth   = (bit_cnt == 4'd8);
  wire rd_data = rd_o & (phase_o == PH_SUB) & ~ninth;
  // a phase whose ninth bit is still owed when the frame stops
  wire owed    = ninth & (phase_o != PH_OVER) & ~(rd_o & phase_o == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1; sclk_q <= 1'b1; active <= 1'b0;
      match_o <= 1'b0; rd_o <= 1'b0; phase_o <= PH_ID; bit_cnt <= '0;
      shreg <= '0; sub_o <= '0; we_o <= 1'b0; err_o <= 1'b0;
    end else begin
      en_q   <= en_s_i;
      sclk_q <= sclk_i;
      we_o   <= 1'b0;
      err_o  <= 1'b0;
      if (start) begin
        active <= 1'b1; match_o <= 1'b0; rd_o <= 1'b0;
        phase_o <= PH_ID; bit_cnt <= '0;
      end else if (stop) begin
        active  <= 1'b0;
        bit_cnt <= '0;
        phase_o <= PH_ID;
        if (active && match_o && owed) err_o <= 1'b1;
      end else if (active && rise) begin
        if (!ninth) begin
          shreg   <= {shreg[6:0], sdat_i};
          bit_cnt <= bit_cnt + 4'd1;
          if (phase_o == PH_ID && bit_cnt == 4'd7) begin
            match_o <= (shreg[6:0] == DEV_ID);
            rd_o    <= sdat_i;
          end
        end else begin
          bit_cnt <= '0;
          if (phase_o != PH_OVER) phase_o <= phase_e'(phase_o + 2'd1);
          if (match_o && !rd_o && phase_o == PH_SUB)  sub_o <= shreg[ADDR_W-1:0];
          if (match_o && !rd_o && phase_o == PH_DATA) we_o  <= 1'b1;
        end
      end
    end
  end

  assign wdata_o    = shreg;
  // next bit position is known at each falling edge
  assign plan_vld_o = active & ~en_s_i & fall;
  assign plan_oe_o  = match_o & ((ninth & ((~rd_o & phase_o != PH_OVER) |
                                           (rd_o & phase_o == PH_ID))) | rd_data);
  assign plan_dat_o = rd_data ? rd_byte_i[~bit_cnt[2:0]] : 1'b0;
endmodule

// File: rtl/cam_ctl_drive.sv
module cam_ctl_drive #(
  parameter int HOLD_CYC = 93
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_s_i,
  input  logic plan_vld_i,
  input  logic plan_oe_i,
  input  logic plan_dat_i,
  output logic oe_o,
  output logic dat_o
);
  localparam int TMR_W = $clog2(HOLD_CYC + 1);

  logic [TMR_W-1:0] tmr;
  logic             pend, want_oe, want_dat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr <= '0; pend <= 1'b0; want_oe <= 1'b0; want_dat <= 1'b0;
      oe_o <= 1'b0; dat_o <= 1'b0;
    end else if (en_s_i) begin
      pend <= 1'b0; tmr <= '0; oe_o <= 1'b0;
    end else if (plan_vld_i) begin
      pend <= 1'b1; tmr <= TMR_W'(HOLD_CYC);
      want_oe <= plan_oe_i; want_dat <= plan_dat_i;
    end else if (pend) begin
      tmr <= tmr - 1'b1;
      if (tmr <= TMR_W'(1)) begin
        pend <= 1'b0; oe_o <= want_oe; dat_o <= want_dat;
      end
    end
  end
endmodule

// File: rtl/cam_ctl_slave.sv
module cam_ctl_slave
  import cam_ctl_pkg::*;
#(
  parameter logic [6:0]        DEV_ID      = 7'h21,
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = '1,
  parameter int                HOLD_CYC    = 93,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cam_en_ni,
  input  logic              cam_clk_i,
  input  logic              cam_dat_i,
  output logic              cam_dat_o,
  output logic              cam_dat_oe_o,
  input  logic              loc_we_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [7:0]        loc_wdata_i,
  output logic [7:0]        loc_rdata_o
);
  logic              en_s, sclk_s, sdat_s, sclk_m, sdat_m;
  logic              match, rd, we, err, plan_vld, plan_oe, plan_dat;
  phase_e            phase;
  logic [ADDR_W-1:0] sub;
  byte_t             wdata, rd_byte;

  cam_ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cam_en_ni, cam_clk_i, cam_dat_i}),
    .q_o({en_s, sclk_s, sdat_s})
  );

  // a released bus must look idle to the decoder
  assign sclk_m = en_s | sclk_s;
  assign sdat_m = en_s | sdat_s;

  cam_ctl_frame #(.DEV_ID(DEV_ID), .ADDR_W(ADDR_W)) u_frame (
    .clk_i, .rst_ni, .en_s_i(en_s), .sclk_i(sclk_m), .sdat_i(sdat_m),
    .rd_byte_i(rd_byte), .match_o(match), .rd_o(rd), .phase_o(phase),
    .sub_o(sub), .we_o(we), .wdata_o(wdata), .err_o(err),
    .plan_vld_o(plan_vld), .plan_oe_o(plan_oe), .plan_dat_o(plan_dat)
  );

  cam_ctl_regs #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_regs (
    .clk_i, .rst_ni, .err_set_i(err), .bus_we_i(we), .bus_waddr_i(sub),
    .bus_wdata_i(wdata), .bus_raddr_i(sub), .bus_rdata_o(rd_byte),
    .loc_we_i, .loc_addr_i, .loc_wdata_i, .loc_rdata_o
  );

  cam_ctl_drive #(.HOLD_CYC(HOLD_CYC)) u_drive (
    .clk_i, .rst_ni, .en_s_i(en_s), .plan_vld_i(plan_vld),
    .plan_oe_i(plan_oe), .plan_dat_i(plan_dat),
    .oe_o(cam_dat_oe_o), .dat_o(cam_dat_o)
  );
endmodule

// File: rtl/cam_ctl_slave_chk.sv
module cam_ctl_slave_chk
  import cam_ctl_pkg::*;
#(
  parameter int HOLD_CYC = 93
) (
  input logic   clk_i,
  input logic   rst_ni,
  input logic   en_s,
  input logic   sclk_m,
  input logic   oe,
  input logic   dat,
  input logic   match,
  input logic   rd,
  input phase_e phase
);
  logic        sclk_q;
  logic [15:0] since_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1; since_fall <= '1;
    end else begin
      sclk_q <= sclk_m;
      if (sclk_q && !sclk_m) since_fall <= 16'd1;
      else if (since_fall != '1) since_fall <= since_fall + 16'd1;
    end
  end

  p_oe_clk_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe) && !en_s) |-> !sclk_m);
  p_oe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(oe) && !en_s) |-> (since_fall >= 16'(HOLD_CYC)));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s |=> !oe);
  p_foreign_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe |-> match);
  p_na_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && rd && phase == PH_DATA) |-> !oe);
  p_ninth_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && !rd) |-> !dat);
endmodule

bind cam_ctl_slave cam_ctl_slave_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_s(en_s), .sclk_m(sclk_m),
  .oe(cam_dat_oe_o), .dat(cam_dat_o), .match(match), .rd(rd), .phase(phase)
);

// File: tb/cam_ctl_slave_tb.sv
module cam_ctl_slave_tb;
  localparam int         HP   = 32;
  localparam int         HOLD = 8;
  localparam logic [7:0] WID  = 8'h42;  // {7'h21, write}
  localparam logic [7:0] RID  = 8'h43;  // {7'h21, read}
  localparam logic [7:0] XID  = 8'h44;  // foreign identifier
  // {is_read, pointer, data}
  localparam logic [16:0] TV [8] = '{
    {1'b0, 8'h01, 8'hA5}, {1'b0, 8'h02, 8'h3C}, {1'b0, 8'h0E, 8'hFF},
    {1'b1, 8'h01, 8'hA5}, {1'b1, 8'h02, 8'h3C}, {1'b1, 8'h0E, 8'hFF},
    {1'b0, 8'h01, 8'h00}, {1'b1, 8'h01, 8'h00}};

  logic clk = 0, rst_n = 0;
  logic cam_en_n = 1, cam_clk = 1, m_oe = 0, m_dat = 1;
  logic loc_we = 0;
  logic [3:0] loc_addr = 0;
  logic [7:0] loc_wdata = 0, loc_rdata;
  logic s_dat, s_oe;
  wire  line = s_oe ? s_dat : (m_oe ? m_dat : 1'b1);
  int   n_cmp = 0, n_fail = 0, oe_hits = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  cam_ctl_slave #(.HOLD_CYC(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cam_en_ni(cam_en_n), .cam_clk_i(cam_clk),
    .cam_dat_i(line), .cam_dat_o(s_dat), .cam_dat_oe_o(s_oe),
    .loc_we_i(loc_we), .loc_addr_i(loc_addr), .loc_wdata_i(loc_wdata),
    .loc_rdata_o(loc_rdata)
  );

  always @(negedge clk) if (s_oe) oe_hits++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loc_rd(input logic [3:0] a, output logic [7:0] d);
    @(posedge clk); #1 loc_addr = a;
    @(posedge clk); #1 d = loc_rdata;
  endtask

  task automatic loc_wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 loc_we = 1; loc_addr = a; loc_wdata = d;
    @(posedge clk); #1 loc_we = 0;
  endtask

  task automatic sbit(input logic v, input bit drv,
                      output logic seen, output bit eoe, output bit hoe);
    @(posedge clk); #1 cam_clk = 0;
    repeat (4) @(posedge clk);
    #1 eoe = s_oe;
    repeat (HP/2 - 4) @(posedge clk);
    #1 m_oe = drv; m_dat = v;
    repeat (HP/2) @(posedge clk);
    #1 cam_clk = 1;
    repeat (HP/2) @(posedge clk);
    #1 seen = line; hoe = s_oe;
    repeat (HP/2 - 1) @(posedge clk);
  endtask

  // cut < 0 sends whole phases; ghost keeps the enable high
  task automatic xfer(input logic [7:0] b0, b1, b2, input int nph, input bit rdf,
                      input int cut, input bit ghost, output logic [7:0] rbyte,
                      output logic [2:0] ack, output bit eoe8, output bit na_oe);
    logic [7:0] by [3];
    int total;
    by[0] = b0; by[1] = b1; by[2] = b2;
    total = (cut >= 0) ? cut : nph * 9;
    rbyte = '0; ack = '1; eoe8 = 0; na_oe = 0;
    @(posedge clk); #1 m_oe = 1; m_dat = 1;
    if (!ghost) cam_en_n = 0;
    repeat (HP) @(posedge clk);
    for (int i = 0; i < total; i++) begin
      int  ph, b;
      bit  drv, e, h;
      logic v, s;
      ph  = i / 9; b = i % 9;
      drv = (b < 8) ? !(rdf && ph == 1) : (rdf && ph == 1);
      v   = (b < 8) ? by[ph][7-b] : 1'b1;
      sbit(v, drv, s, e, h);
      if (rdf && ph == 1 && b < 8) rbyte[7-b] = s;
      if (b == 8 && ph < 3) ack[ph] = s;
      if (i == 8) eoe8 = e;
      if (rdf && ph == 1 && b == 8) na_oe = h;
    end
    repeat (HP/2) @(posedge clk);
    #1 cam_en_n = 1; m_oe = 0;
    repeat (2*HP) @(posedge clk);
  endtask

  initial begin
    logic [7:0] d, rb;
    logic [2:0] ack;
    bit e8, na;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1 chk(s_oe == 0, "R1 oe after reset", s_oe, 0);
    loc_rd(4'hF, d); chk(d == 8'h55, "R1 status reset", d, 8'h55);
    loc_rd(4'h3, d); chk(d == 8'h00, "R1 plain reset", d, 8'h00);

    for (int k = 0; k < 8; k++) begin
      logic [16:0] t;
      t = TV[k];
      if (!t[16]) begin
        xfer(WID, t[15:8], t[7:0], 3, 0, -1, 0, rb, ack, e8, na);
        chk(ack == 3'b000, "R6 ninth bits driven low", ack, 0);
        chk(e8 == 0, "R7 oe not before hold", e8, 0);
        loc_rd(t[11:8], d); chk(d == t[7:0], "R2 three-phase write", d, t[7:0]);
      end else begin
        xfer(WID, t[15:8], 8'h00, 2, 0, -1, 0, rb, ack, e8, na);
        xfer(RID, 8'h00, 8'h00, 2, 1, -1, 0, rb, ack, e8, na);
        chk(rb == t[7:0], "R4 read after pointer write", rb, t[7:0]);
        chk(na == 0, "R5 released for NA bit", na, 0);
      end
    end

    // R3 foreign identifier
    oe_hits = 0;
    xfer(XID, 8'h01, 8'h77, 3, 0, -1, 0, rb, ack, e8, na);
    chk(oe_hits == 0, "R3 no drive on foreign frame", oe_hits, 0);
    chk(ack == 3'b111, "R3 ninth bits left floating", ack, 3'b111);
    loc_rd(4'h1, d); chk(d == 8'h00, "R3 no write on foreign frame", d, 8'h00);

    // R11 enable held high
    oe_hits = 0;
    xfer(WID, 8'h01, 8'hEE, 3, 0, -1, 1, rb, ack, e8, na);
    chk(oe_hits == 0, "R11 no drive while idle", oe_hits, 0);
    loc_rd(4'h1, d); chk(d == 8'h00, "R11 no write while idle", d, 8'h00);

    // R10 cut partway through the data byte
    xfer(WID, 8'h02, 8'h99, 3, 0, 22, 0, rb, ack, e8, na);
    loc_rd(4'h2, d); chk(d == 8'h3C, "R10 partial byte dropped", d, 8'h3C);
    loc_rd(4'hF, d); chk(d == 8'h55, "R10 status unchanged", d, 8'h55);

    // R8 cut after eight data bits, ninth missing
    xfer(WID, 8'h02, 8'h99, 3, 0, 26, 0, rb, ack, e8, na);
    loc_rd(4'hF, d); chk(d == 8'h54, "R8 status records missing ninth", d, 8'h54);
    loc_rd(4'h2, d); chk(d == 8'h3C, "R8 no write without ninth", d, 8'h3C);

    // R9 status over the bus
    xfer(WID, 8'h0F, 8'h00, 2, 0, -1, 0, rb, ack, e8, na);
    xfer(RID, 8'h00, 8'h00, 2, 1, -1, 0, rb, ack, e8, na);
    chk(rb == 8'h54, "R9 bus read of status", rb, 8'h54);
    xfer(WID, 8'h0F, 8'h55, 3, 0, -1, 0, rb, ack, e8, na);
    loc_rd(4'hF, d); chk(d == 8'h55, "R9 bus write of status", d, 8'h55);

    // R12 local port
    loc_wr(4'h5, 8'h5A);
    loc_rd(4'h5, d); chk(d == 8'h5A, "R12 local write and read", d, 8'h5A);
    xfer(WID, 8'h05, 8'h00, 2, 0, -1, 0, rb, ack, e8, na);
    xfer(RID, 8'h00, 8'h00, 2, 1, -1, 0, rb, ack, e8, na);
    chk(rb == 8'h5A, "R12 bus read of local write", rb, 8'h5A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule